// File: doc/BRIEF.md
# NAND Flash Bus Access Sequencer

This block sits between a simple host request port and a raw NAND flash bus. Each host request names a chip and one of three windows for that chip (data, command or address) and carries a write flag and write data. The block then runs one access on the flash pins as a fixed sequence of phases. First the chip enable is driven low for a setup period. Then the read or write strobe is pulsed. Finally the chip enable is held for a hold period. When the hold period ends, the block pulses ready back to the host.

A command-window access raises the command latch line for the whole access, and an address-window access raises the address latch line. Data-window accesses take their setup and hold lengths from one timing pair, while command and address accesses take theirs from a second pair. Every count is programmed as N and lasts N+1 clock cycles. A write keeps the data bus tristated for a programmable number of cycles from the start of the access. The strobe can be stretched by an active-low wait line from the flash. A read strobe is kept back after a command or address access until a programmable gap has elapsed since the latch line fell.

Top module: `nand_seq`

## Requirements
- R1: While reset is held, every chip enable, the read strobe and the write strobe are high, both latch lines are low, the data output enable is low and ready is low.
- R2: req_addr is {chip index, window}, with the window in bits [1:0] (00 data, 01 command, 10 address, 11 handled as data). Only the addressed chip's enable goes low, from the first setup cycle to the last hold cycle.
- R3: A command-window access holds nand_cle high in every cycle its chip enable is low. An address-window access does the same with nand_ale. A data access raises neither line.
- R4: The chip enable is low for SET+1 cycles before the strobe falls. SET is cfg_set_data for data-window accesses and cfg_set_ctl for command and address accesses.
- R5: With the wait line high, the strobe stays low for cfg_wait+1 cycles (1 up to 256).
- R6: The strobe is not released until the wait line, passed through a two-stage synchronizer, reads high. If nand_wait_n rises during strobe cycle j (counting from 0) and cfg_wait is 0, the strobe lasts j+3 cycles.
- R7: After the strobe rises, the chip enable stays low for HOLD+1 cycles. HOLD is cfg_hold_data for data-window accesses and cfg_hold_ctl for command and address accesses.
- R8: On writes the data output enable stays low for cfg_hiz+1 cycles from the first setup cycle. After that it is high, with the request's write data on nand_dq_o, up to the last hold cycle. On reads the output enable never rises, whatever cfg_hiz holds.
- R9: A read returns the value on nand_dq_i during the last strobe cycle on rdata when ready is high.
- R10: Ready is high for exactly one cycle, the cycle after the last hold cycle. All chip enables are high in that cycle.
- R11: After a command access, the next read strobe falls no sooner than cfg_cle_re+1 cycles after nand_cle falls. The rule is the same after an address access, using cfg_ale_re and nand_ale. Setup is lengthened to meet the gap and is never shortened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, held until ready |
| req_addr | input | CS_W+2 | Chip index and window select |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Read data captured from the flash |
| cfg_cle_re | input | GW | Command latch to read strobe gap, N+1 cycles |
| cfg_ale_re | input | GW | Address latch to read strobe gap, N+1 cycles |
| cfg_hiz | input | TW | Write tristate cycles, N+1 |
| cfg_wait | input | TW | Strobe width, N+1 |
| cfg_set_data | input | TW | Setup length for data-window accesses |
| cfg_hold_data | input | TW | Hold length for data-window accesses |
| cfg_set_ctl | input | TW | Setup length for command and address accesses |
| cfg_hold_ctl | input | TW | Hold length for command and address accesses |
| nand_ce_n | output | NCS | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_dq_o | output | DW | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | DW | Data bus input value |
| nand_wait_n | input | 1 | Active-low wait from the flash |

## Verification
All phase lengths come from a single down-counter and a phase state, so a wrong count or a state transition taken too early shows up at once as a setup, strobe or hold length that is off by whole cycles. It is visible within the access in which it happens. A gap counter left with the wrong value appears only on the next read: that read's strobe start moves relative to the fall of the latch line. A stale hi-Z flag shows as an output enable that rises too early or too late in the first cycles of a write, and a misrouted chip select shows on the enable pins in the first setup cycle.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_STROBE = 3'd2,
      ST_HOLD   = 3'd3,
      ST_DONE   = 3'd4
   } nseq_state_e;

   typedef enum logic [1:0] {
      WIN_DATA = 2'b00,
      WIN_CMD  = 2'b01,
      WIN_ADDR = 2'b10,
      WIN_ALT  = 2'b11
   } nseq_win_e;
endpackage

// File: rtl/nseq_sync.sv
module nseq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("nseq_sync needs at least two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/nseq_decode.sv
module nseq_decode
   import nseq_pkg::*;
#(
   parameter int NCS  = 2,
   parameter int CS_W = 1
) (
   input  logic [CS_W+1:0] sel,
   output logic [NCS-1:0]  cs_hot,
   output nseq_win_e       win,
   output logic            ctl
);
   logic [CS_W-1:0] idx;
   assign idx = sel[CS_W+1:2];

   for (genvar i = 0; i < NCS; i++) begin : g_cs
      assign cs_hot[i] = (idx == CS_W'(i));
   end

   assign win = nseq_win_e'(sel[1:0]);
   assign ctl = (win == WIN_CMD) || (win == WIN_ADDR);
endmodule

// File: rtl/nseq_gap.sv
module nseq_gap #(
   parameter int GW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [GW-1:0] load_val,
   output logic          gap_ok
);
   localparam int CW = GW + 1;
   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left_q <= '0;
      else if (load)           left_q <= {1'b0, load_val} + CW'(1);
      else if (left_q != '0)   left_q <= left_q - CW'(1);
   end

   assign gap_ok = (left_q <= CW'(1));
endmodule

// File: rtl/nand_seq.sv
module nand_seq
   import nseq_pkg::*;
#(
   parameter int DW  = 8,
   parameter int NCS = 2,
   parameter int TW  = 8,
   parameter int GW  = 4,
   localparam int CS_W = (NCS > 1) ? $clog2(NCS) : 1,
   localparam int SW   = CS_W + 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req,
   input  logic [SW-1:0]  req_addr,
   input  logic           req_we,
   input  logic [DW-1:0]  req_wdata,
   output logic           ready,
   output logic [DW-1:0]  rdata,
   input  logic [GW-1:0]  cfg_cle_re,
   input  logic [GW-1:0]  cfg_ale_re,
   input  logic [TW-1:0]  cfg_hiz,
   input  logic [TW-1:0]  cfg_wait,
   input  logic [TW-1:0]  cfg_set_data,
   input  logic [TW-1:0]  cfg_hold_data,
   input  logic [TW-1:0]  cfg_set_ctl,
   input  logic [TW-1:0]  cfg_hold_ctl,
   output logic [NCS-1:0] nand_ce_n,
   output logic           nand_cle,
   output logic           nand_ale,
   output logic           nand_re_n,
   output logic           nand_we_n,
   output logic [DW-1:0]  nand_dq_o,
   output logic           nand_dq_oe,
   input  logic [DW-1:0]  nand_dq_i,
   input  logic           nand_wait_n
);
   if (NCS < 2)  begin : g_bad_ncs $error("nand_seq needs NCS >= 2"); end
   if (DW < 1)   begin : g_bad_dw  $error("nand_seq needs DW >= 1");  end
   if (TW < 1)   begin : g_bad_tw  $error("nand_seq needs TW >= 1");  end
   if (GW < 1)   begin : g_bad_gw  $error("nand_seq needs GW >= 1");  end

   nseq_state_e    st_q;
   logic [TW-1:0]  cnt_q;
   logic [TW-1:0]  hiz_q;
   logic           hiz_done_q;
   logic [NCS-1:0] cs_q;
   nseq_win_e      win_q;
   logic           ctl_q;
   logic           we_q;
   logic [DW-1:0]  wd_q;
   logic [DW-1:0]  rd_q;

   logic [NCS-1:0] dec_cs;
   nseq_win_e      dec_win;
   logic           dec_ctl;
   logic           wait_s;
   logic           gap_ok;
   logic           gap_load;
   logic           active;

   nseq_decode #(.NCS(NCS), .CS_W(CS_W)) u_dec (
      .sel(req_addr), .cs_hot(dec_cs), .win(dec_win), .ctl(dec_ctl)
   );

   nseq_sync #(.STAGES(2), .RST_VAL(1'b1)) u_wsync (
      .clk(clk), .rst_n(rst_n), .d(nand_wait_n), .q(wait_s)
   );

   assign gap_load = (st_q == ST_HOLD) && (cnt_q == '0) && ctl_q;

   nseq_gap #(.GW(GW)) u_gap (
      .clk(clk), .rst_n(rst_n), .load(gap_load),
      .load_val((win_q == WIN_CMD) ? cfg_cle_re : cfg_ale_re),
      .gap_ok(gap_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         cnt_q      <= '0;
         hiz_q      <= '0;
         hiz_done_q <= 1'b0;
         cs_q       <= '0;
         win_q      <= WIN_DATA;
         ctl_q      <= 1'b0;
         we_q       <= 1'b0;
         wd_q       <= '0;
         rd_q       <= '0;
      end else begin
         if (st_q == ST_SETUP || st_q == ST_STROBE || st_q == ST_HOLD) begin
            if (hiz_q != '0) hiz_q <= hiz_q - TW'(1);
            else             hiz_done_q <= 1'b1;
         end
         case (st_q)
            ST_IDLE: if (req) begin
               st_q       <= ST_SETUP;
               cs_q       <= dec_cs;
               win_q      <= dec_win;
               ctl_q      <= dec_ctl;
               we_q       <= req_we;
               wd_q       <= req_wdata;
               cnt_q      <= dec_ctl ? cfg_set_ctl : cfg_set_data;
               hiz_q      <= cfg_hiz;
               hiz_done_q <= 1'b0;
            end
            ST_SETUP: begin
               if (cnt_q != '0) cnt_q <= cnt_q - TW'(1);
               else if (we_q || gap_ok) begin
                  st_q  <= ST_STROBE;
                  cnt_q <= cfg_wait;
               end
            end
            ST_STROBE: begin
               if (cnt_q != '0) cnt_q <= cnt_q - TW'(1);
               else if (wait_s) begin
                  st_q  <= ST_HOLD;
                  cnt_q <= ctl_q ? cfg_hold_ctl : cfg_hold_data;
                  if (!we_q) rd_q <= nand_dq_i;
               end
            end
            ST_HOLD: begin
               if (cnt_q != '0) cnt_q <= cnt_q - TW'(1);
               else             st_q  <= ST_DONE;
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign active     = (st_q == ST_SETUP) || (st_q == ST_STROBE) || (st_q == ST_HOLD);
   assign nand_ce_n  = active ? ~cs_q : '1;
   assign nand_cle   = active && (win_q == WIN_CMD);
   assign nand_ale   = active && (win_q == WIN_ADDR);
   assign nand_re_n  = !((st_q == ST_STROBE) && !we_q);
   assign nand_we_n  = !((st_q == ST_STROBE) && we_q);
   assign nand_dq_o  = wd_q;
   assign nand_dq_oe = active && we_q && hiz_done_q;
   assign ready      = (st_q == ST_DONE);
   assign rdata      = rd_q;

   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_idle: assert (&nand_ce_n && !nand_cle && !nand_ale && nand_re_n
                                  && nand_we_n && !nand_dq_oe && !ready);
      end
   end

   a_r2_one_chip: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~nand_ce_n) <= 1);
   a_r3_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));
   a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      nand_re_n || nand_we_n);
   a_r6_wait_stretch: assert property (@(posedge clk) disable iff (!rst_n)
      ((!nand_re_n || !nand_we_n) && !wait_s) |=> (!nand_re_n || !nand_we_n));
   a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      nand_dq_oe |-> nand_re_n);
   a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);
   a_r10_ready_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (&nand_ce_n));
endmodule

// File: tb/nand_seq_test.sv
`timescale 1ns/1ps
module nand_seq_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0;
   logic [2:0] req_addr = '0;
   logic       req_we = 1'b0;
   logic [7:0] req_wdata = '0;
   logic       ready;
   logic [7:0] rdata;
   logic [3:0] cfg_cle_re = '0, cfg_ale_re = '0;
   logic [7:0] cfg_hiz = '0, cfg_wait = '0, cfg_set_data = '0, cfg_hold_data = '0;
   logic [7:0] cfg_set_ctl = '0, cfg_hold_ctl = '0;
   logic [1:0] nand_ce_n;
   logic       nand_cle, nand_ale, nand_re_n, nand_we_n, nand_dq_oe;
   logic [7:0] nand_dq_o;
   logic [7:0] nand_dq_i = '0;
   logic       nand_wait_n = 1'b1;

   int compared = 0, mismatched = 0;
   int cyc = 0;
   int last_cle = 0, last_ale = 0;
   int s_setup, s_strobe, s_hold, s_hiz, s_oe, s_cle, s_ale, s_active;
   int s_ce_bad, s_wd_bad, s_first_strobe, s_done;
   int wait_release;
   logic [7:0] s_rdata;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   nand_seq uut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_we(req_we),
      .req_wdata(req_wdata), .ready(ready), .rdata(rdata),
      .cfg_cle_re(cfg_cle_re), .cfg_ale_re(cfg_ale_re), .cfg_hiz(cfg_hiz),
      .cfg_wait(cfg_wait), .cfg_set_data(cfg_set_data), .cfg_hold_data(cfg_hold_data),
      .cfg_set_ctl(cfg_set_ctl), .cfg_hold_ctl(cfg_hold_ctl),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_re_n(nand_re_n), .nand_we_n(nand_we_n), .nand_dq_o(nand_dq_o),
      .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_wait_n(nand_wait_n)
   );

   task automatic check(input string tag, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic access(input int cs, input logic [1:0] win, input logic we,
                         input logic [7:0] wd);
      logic [1:0] exp_ce;
      exp_ce = ~(2'b01 << cs);
      s_setup = 0; s_strobe = 0; s_hold = 0; s_hiz = 0; s_oe = 0; s_cle = 0;
      s_ale = 0; s_active = 0; s_ce_bad = 0; s_wd_bad = 0; s_first_strobe = -1;
      s_done = 0;
      req_addr = {cs[0], win}; req_we = we; req_wdata = wd; req = 1'b1;
      for (int n = 0; n < 3000; n++) begin
         @(negedge clk);
         if (ready) begin
            s_rdata = rdata;
            s_done = 1;
            if (nand_ce_n != 2'b11) s_ce_bad++;
            break;
         end
         if (nand_ce_n != 2'b11) begin
            s_active++;
            if (nand_ce_n != exp_ce) s_ce_bad++;
            if (!nand_re_n || !nand_we_n) begin
               s_strobe++;
               if (s_first_strobe < 0) s_first_strobe = cyc;
               nand_dq_i = 8'(8'hA0 + s_strobe);
               if (s_strobe == wait_release + 1) nand_wait_n = 1'b1;
            end else if (s_strobe == 0) s_setup++;
            else s_hold++;
            if (nand_cle) s_cle++;
            if (nand_ale) s_ale++;
            if (nand_dq_oe) begin
               s_oe++;
               if (nand_dq_o != wd) s_wd_bad++;
            end else if (s_oe == 0) s_hiz++;
         end
         if (nand_cle) last_cle = cyc;
         if (nand_ale) last_ale = cyc;
      end
      req = 1'b0;
      check("R10 access completes with ready", s_done, 1);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      check("R1 chip enables high", int'(nand_ce_n), 3);
      check("R1 latches low", int'({nand_cle, nand_ale}), 0);
      check("R1 strobes high", int'({nand_re_n, nand_we_n}), 3);
      check("R1 bus tristated", int'(nand_dq_oe), 0);
      check("R1 ready low", int'(ready), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_data_write;
      cfg_set_data = 2; cfg_hold_data = 1; cfg_set_ctl = 0; cfg_hold_ctl = 4;
      cfg_wait = 3; cfg_hiz = 1;
      access(0, 2'b00, 1'b1, 8'h5C);
      check("R2 only chip 0 enabled", s_ce_bad, 0);
      check("R4 data setup", s_setup, 3);
      check("R5 strobe width", s_strobe, 4);
      check("R7 data hold", s_hold, 2);
      check("R8 write hi-z cycles", s_hiz, 2);
      check("R8 write drive cycles", s_oe, 7);
      check("R8 write data value", s_wd_bad, 0);
      check("R3 data raises no latch", s_cle + s_ale, 0);
   endtask

   task automatic t_cmd_addr_write;
      cfg_hiz = 0;
      access(1, 2'b01, 1'b1, 8'h70);
      check("R2 only chip 1 enabled", s_ce_bad, 0);
      check("R3 cle over whole command", s_cle, s_active);
      check("R3 no ale on command", s_ale, 0);
      check("R4 ctl setup", s_setup, 1);
      check("R7 ctl hold", s_hold, 5);
      access(0, 2'b10, 1'b1, 8'h12);
      check("R3 ale over whole address", s_ale, s_active);
      check("R3 no cle on address", s_cle, 0);
      check("R7 ctl hold on address", s_hold, 5);
   endtask

   task automatic t_gap_read;
      int lc;
      cfg_set_data = 0; cfg_hold_data = 0; cfg_wait = 2; cfg_hiz = 5;
      cfg_cle_re = 6; cfg_ale_re = 9; cfg_hold_ctl = 0;
      access(0, 2'b01, 1'b1, 8'h00);
      lc = last_cle;
      access(0, 2'b00, 1'b0, 8'h00);
      check("R11 cle to re gap", s_first_strobe - lc, 8);
      check("R11 setup stretched after cle", s_setup, 5);
      check("R8 read ignores hi-z count", s_oe, 0);
      check("R9 read data at last strobe", int'(s_rdata), 8'hA3);
      access(1, 2'b10, 1'b1, 8'h00);
      lc = last_ale;
      access(1, 2'b00, 1'b0, 8'h00);
      check("R11 ale to re gap", s_first_strobe - lc, 11);
      check("R11 setup stretched after ale", s_setup, 8);
      cfg_set_data = 12; cfg_cle_re = 2;
      access(0, 2'b01, 1'b1, 8'h00);
      access(0, 2'b00, 1'b0, 8'h00);
      check("R11 long setup not shortened", s_setup, 13);
   endtask

   task automatic t_wait_stretch;
      cfg_set_data = 1; cfg_wait = 0;
      nand_wait_n = 1'b0; wait_release = 5;
      access(1, 2'b00, 1'b0, 8'h00);
      wait_release = -10;
      check("R6 strobe stretched by wait", s_strobe, 8);
      check("R9 read data after stretch", int'(s_rdata), 8'hA8);
   endtask

   task automatic t_long_and_alt;
      cfg_wait = 255; cfg_set_data = 0; cfg_hold_data = 0; cfg_hiz = 20;
      access(0, 2'b00, 1'b1, 8'h33);
      check("R5 maximum strobe width", s_strobe, 256);
      cfg_wait = 0;
      access(1, 2'b00, 1'b1, 8'h44);
      check("R8 long hi-z keeps bus off", s_oe, 0);
      cfg_set_data = 3; cfg_set_ctl = 7;
      access(1, 2'b11, 1'b0, 8'h00);
      check("R2 window 11 as data setup", s_setup, 4);
      check("R3 window 11 raises no latch", s_cle + s_ale, 0);
   endtask

   task automatic t_ready_pulse;
      access(0, 2'b00, 1'b0, 8'h00);
      @(negedge clk);
      check("R10 ready lasts one cycle", int'(ready), 0);
      check("R10 bus idle after ready", int'(nand_ce_n), 3);
   endtask

   initial begin
      wait_release = -10;
      t_reset();
      @(negedge clk);
      t_data_write();
      t_cmd_addr_write();
      t_gap_read();
      t_wait_stretch();
      t_long_and_alt();
      t_ready_pulse();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule